// File: doc/BRIEF.md
# Two-Read Byte Output Multiplexer

This block hands a converter result, a sign bit plus a 12-bit magnitude, to a host over an 8-bit data bus. The host needs two read accesses to collect it. A read is an interval during which both the active-low select and the active-low read strobe are low. The first read after a new result returns the upper part of the word. In that byte the upper four lines all repeat the sign. The second read returns the lower eight magnitude bits. After that, reads keep alternating between the two bytes.

All inputs are sampled on the rising clock edge. The byte for a read is captured in the cycle the read begins. It is driven from the next cycle until one cycle after the read ends, together with an output-enable that stands in for the tri-state control. When the enable is low, the data lines are held at zero. A result-valid strobe loads a new word and points the next read at the upper byte. A word that arrives during a read does not disturb the byte being presented.

Top module: `rdx_two_read_mux`

## Requirements
- R1: After reset, `bus_oe` is 0 and `bus_q` is 0, and the first read returns the upper byte of an all-zero word.
- R2: `bus_oe` is 1 in the cycle after a clock edge that samples both `cs_n` and `rd_n` low. It is 0 in the cycle after an edge that samples either of them high.
- R3: Whenever `bus_oe` is 0, `bus_q` is all zeros.
- R4: The first read after `res_valid` returns the upper byte. Lines 3:0 carry word bits 11:8, where bit 11 is the magnitude MSB. Lines 7:4 each carry word bit 12, the sign.
- R5: The second read after `res_valid` returns word bits 7:0 on lines 7:0, with the LSB on line 0.
- R6: Every further completed read switches between the upper and lower byte, so the third read returns the upper byte again.
- R7: While `bus_oe` stays 1, `bus_q` does not change, even if `res_valid` pulses with a different word.
- R8: A `res_valid` pulse that arrives during a read makes the next read return the upper byte of the new word.
- R9: If `res_valid` is sampled in the same cycle that a read begins, that read returns the upper byte of the new word, and the read after it returns the lower byte.
- R10: Holding only one of `cs_n` or `rd_n` low neither enables the bus nor advances the byte choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_word | input | 13 | Result word: bit 12 is the sign, bits 11:0 the magnitude |
| res_valid | input | 1 | One-cycle strobe that loads `res_word` |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| bus_q | output | 8 | Data bus, zero when not enabled |
| bus_oe | output | 1 | High while the bus must be driven |

## Verification
A new result can arrive in the same cycle as a read boundary, either the cycle the read starts or a cycle inside the read. In that case loading the word and capturing or advancing the byte choice compete. The bench provokes the first case by raising `res_valid` together with the select and read strobes, and the second by pulsing it in the middle of an access. It then judges the outcome at the ports. The byte already on the bus must stay unchanged, and the next read, or the current one when the two start together, must return the upper byte of the new word.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  typedef enum logic {
    SEL_HIGH = 1'b0,
    SEL_LOW  = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/rdx_access_detect.sv
module rdx_access_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  output logic act,
  output logic start_evt,
  output logic done_evt
);
  logic act_q;

  assign act       = ~cs_n & ~rd_n;
  assign start_evt = act & ~act_q;
  assign done_evt  = ~act & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end
endmodule

// File: rtl/rdx_byte_pointer.sv
module rdx_byte_pointer
  import rdx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      res_valid,
  input  logic      start_evt,
  input  logic      done_evt,
  output byte_sel_e sel,
  output logic      fresh
);
  byte_sel_e sel_q;
  logic      fresh_q;

  // fresh: a word arrived after the current read began; its end must not flip
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SEL_HIGH;
      fresh_q <= 1'b0;
    end else begin
      if (res_valid)                sel_q <= SEL_HIGH;
      else if (done_evt && !fresh_q) sel_q <= (sel_q == SEL_HIGH) ? SEL_LOW : SEL_HIGH;
      if (start_evt)      fresh_q <= 1'b0;
      else if (res_valid) fresh_q <= 1'b1;
    end
  end

  assign sel   = sel_q;
  assign fresh = fresh_q;
endmodule

// File: rtl/rdx_byte_hold.sv
module rdx_byte_hold
  import rdx_pkg::*;
#(
  parameter int MAG_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W:0]   res_word,
  input  logic             res_valid,
  input  logic             start_evt,
  input  logic             act,
  input  byte_sel_e        sel,
  output logic [BUS_W-1:0] bus_q,
  output logic             bus_oe
);
  localparam int WORD_W = MAG_W + 1;
  localparam int HI_W   = MAG_W - BUS_W;

  function automatic logic [BUS_W-1:0] upper_byte(input logic [WORD_W-1:0] w);
    logic [BUS_W-1:0] b;
    for (int i = 0; i < BUS_W; i++) begin
      if (i < HI_W) b[i] = w[BUS_W + i];
      else          b[i] = w[MAG_W];
    end
    return b;
  endfunction

  function automatic logic [BUS_W-1:0] lower_byte(input logic [WORD_W-1:0] w);
    return w[BUS_W-1:0];
  endfunction

  logic [WORD_W-1:0] res_q;
  logic [WORD_W-1:0] cap_word;
  byte_sel_e         cap_sel;
  logic [BUS_W-1:0]  hold_q;
  logic              oe_q;

  assign cap_word = res_valid ? res_word : res_q;
  assign cap_sel  = res_valid ? SEL_HIGH : sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      hold_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (res_valid) res_q <= res_word;
      if (start_evt)
        hold_q <= (cap_sel == SEL_HIGH) ? upper_byte(cap_word) : lower_byte(cap_word);
      oe_q <= act;
    end
  end

  assign bus_q  = oe_q ? hold_q : '0;
  assign bus_oe = oe_q;
endmodule

// File: rtl/rdx_two_read_mux.sv
module rdx_two_read_mux
  import rdx_pkg::*;
#(
  parameter int MAG_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAG_W:0]   res_word,
  input  logic             res_valid,
  input  logic             cs_n,
  input  logic             rd_n,
  output logic [BUS_W-1:0] bus_q,
  output logic             bus_oe
);
  logic      act;
  logic      start_evt;
  logic      done_evt;
  logic      fresh;
  byte_sel_e sel;
  logic      ptr_low;

  rdx_access_detect i_detect (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
    .act(act), .start_evt(start_evt), .done_evt(done_evt)
  );

  rdx_byte_pointer i_ptr (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid),
    .start_evt(start_evt), .done_evt(done_evt), .sel(sel), .fresh(fresh)
  );

  rdx_byte_hold #(.MAG_W(MAG_W), .BUS_W(BUS_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .res_word(res_word), .res_valid(res_valid),
    .start_evt(start_evt), .act(act), .sel(sel), .bus_q(bus_q), .bus_oe(bus_oe)
  );

  assign ptr_low = (sel == SEL_LOW);
endmodule

// File: rtl/rdx_checker.sv
module rdx_checker #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             res_valid,
  input logic [BUS_W-1:0] bus_q,
  input logic             bus_oe,
  input logic             done_evt,
  input logic             fresh,
  input logic             ptr_low
);
  assert_oe_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n) |=> bus_oe);

  assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |=> !bus_oe);

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_q == '0));

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_q));

  assert_new_word_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !ptr_low);

  assert_alternate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !res_valid && !fresh) |=> (ptr_low != $past(ptr_low)));

  assert_partial_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_evt && !res_valid) |=> $stable(ptr_low));
endmodule

bind rdx_two_read_mux rdx_checker #(.BUS_W(BUS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .res_valid(res_valid),
  .bus_q(bus_q), .bus_oe(bus_oe), .done_evt(done_evt), .fresh(fresh),
  .ptr_low(ptr_low)
);

// File: tb/test_rdx_two_read_mux.sv
`timescale 1ns/1ps
module test_rdx_two_read_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] res_word = '0;
  logic        res_valid = 1'b0;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic [7:0]  bus_q;
  logic        bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rdx_two_read_mux i_rdx_two_read_mux (
    .clk(clk), .rst_n(rst_n), .res_word(res_word), .res_valid(res_valid),
    .cs_n(cs_n), .rd_n(rd_n), .bus_q(bus_q), .bus_oe(bus_oe)
  );

  function automatic int exp_hi(input int w);
    int s;
    s = (w / 4096) % 2;
    return (s * 240) + ((w / 256) % 16);
  endfunction

  function automatic int exp_lo(input int w);
    return w % 256;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int w);
    @(negedge clk);
    res_word  = w[12:0];
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  // full read; checks enable, value, stability and release
  task automatic rd(input string req, input int exp);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check({req, " R2 oe"}, int'(bus_oe), 1);
    check(req, int'(bus_q), exp);
    @(negedge clk);
    check({req, " R7 hold"}, int'(bus_q), exp);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    check({req, " R2 release"}, int'(bus_oe), 0);
    check({req, " R3 zero"}, int'(bus_q), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe", int'(bus_oe), 0);
    check("R1 bus", int'(bus_q), 0);
    rd("R1 first", 0);

    // near-exhaustive sweep of words
    for (int w = 0; w < 8192; w += 5) begin
      load(w);
      rd("R4", exp_hi(w));
      rd("R5", exp_lo(w));
      if (w % 125 == 0) rd("R6", exp_hi(w));
    end
    // extreme words
    load(13'h1FFF); rd("R4 max", 8'hFF); rd("R5 max", 8'hFF); rd("R6 max", 8'hFF);
    load(13'h1000); rd("R4 sign", 8'hF0); rd("R5 sign", 8'h00);
    load(13'h0FFF); rd("R4 pos", 8'h0F); rd("R5 pos", 8'hFF);

    // new word during a read: R7, R8
    load(13'h0A5C);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); check("R7 pre", int'(bus_q), exp_hi(13'h0A5C));
    res_word = 13'h13C7; res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
    check("R7 during", int'(bus_q), exp_hi(13'h0A5C));
    @(negedge clk); check("R7 after", int'(bus_q), exp_hi(13'h0A5C));
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    rd("R8 next", exp_hi(13'h13C7));
    rd("R8 low", exp_lo(13'h13C7));

    // new word in the cycle the read starts: R9
    load(13'h0123);
    rd("R9 prep", exp_hi(13'h0123));
    @(negedge clk);
    res_word = 13'h1E6B; res_valid = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); res_valid = 1'b0;
    check("R9 same", int'(bus_q), exp_hi(13'h1E6B));
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    rd("R9 then low", exp_lo(13'h1E6B));

    // partial selects: R10
    load(13'h0B3D);
    rd("R10 hi", exp_hi(13'h0B3D));
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); check("R10 cs only", int'(bus_oe), 0);
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); check("R10 rd only", int'(bus_oe), 0);
    check("R10 bus", int'(bus_q), 0);
    @(negedge clk); rd_n = 1'b1;
    rd("R10 lo", exp_lo(13'h0B3D));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule